// File: doc/BRIEF.md
# Quarter-Sample Luma Interpolator

This block forms the motion-compensated luma prediction for one square piece of at most 8x8 samples. It takes the reference samples as a padded window one sample per clock. The window has the block size plus five rows and five columns, so 13x13 by default. The caller cuts larger partitions into 8x8 pieces and fetches each window itself. At the start pulse the block takes a 2-bit horizontal phase and a 2-bit vertical phase.

It stores the window and then emits one predicted sample per clock in raster order. Each sample sits at an integer, half-sample or quarter-sample position. Half-sample values come from a six-tap filter run along a row or along a column. The centre position filters unclipped column sums a second time. Quarter-sample values are the rounded mean of two neighbouring integer or half-sample values. When both phases are zero the filters are bypassed and the integer samples pass straight through.

Coordinates below are inside the window. The output at block row r, column c has its integer sample G at window row r+2, column c+2. H is the sample at (r+2, c+3) and M is the sample at (r+3, c+2). T(a..f) = a - 5b + 20c + 20d - 5e + f, and clip limits a value to 0..255.

Top module: `qpel_interp_top`

## Requirements
- R1: While reset is held and just after it, blk_ready is 1 and out_valid and out_last are 0.
- R2: blk_start is taken only while blk_ready is 1, and blk_ready falls in the next cycle. After that the block accepts exactly 169 samples in raster order, one on each cycle with in_valid high. Cycles with in_valid low are skipped.
- R3: After the window is full, exactly 64 samples are emitted in raster order (row-major, column fastest). out_valid is high on each of them and out_last is high only on the 64th.
- R4: With phase x=0 and y=0 the output equals G, with no filtering.
- R5: b = clip((T(row r+2, cols c..c+5)+16)>>5) and s is the same taken on row r+2+1. h = clip((T(col c+2, rows r..r+5)+16)>>5) and m is the same taken on column c+3. Phase (2,0) outputs b and phase (0,2) outputs h.
- R6: For phase (2,2) the output is j. j is formed from V_k = T(col c+k, rows r..r+5), left unclipped, for k=0..5. Then j = clip((T(V_0..V_5)+512)>>10), with arithmetic shifts throughout.
- R7: Every other phase outputs (p+q+1)>>1, with (x,y) giving the pair. (1,0)=G,b; (3,0)=H,b; (0,1)=G,h; (0,3)=M,h; (2,1)=b,j; (2,3)=j,s; (1,2)=h,j; (3,2)=j,m; (1,1)=b,h; (3,1)=b,m; (1,3)=h,s; (3,3)=m,s.
- R8: The phases are sampled only with an accepted blk_start. Changes to them later in the block do not affect its outputs.
- R9: in_valid is ignored while idle and while emitting. blk_start is ignored while blk_ready is 0.
- R10: blk_ready is 1 in the cycle where out_last is 1, and blk_ready rises only at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Begin a block; latches the phases |
| frac_x | input | 2 | Horizontal quarter-sample phase |
| frac_y | input | 2 | Vertical quarter-sample phase |
| in_valid | input | 1 | Window sample present |
| in_sample | input | 8 | Window sample, raster order |
| blk_ready | output | 1 | Idle and able to take blk_start |
| out_valid | output | 1 | Predicted sample present |
| out_sample | output | 8 | Predicted sample |
| out_last | output | 1 | Final sample of the block |

## Verification
The assertions watch the handshake on every cycle. They check that out_last comes only with out_valid and after exactly 63 earlier samples. They check that blk_ready drops after an accepted start and rises only at the end of a block. They also check that the window counter never passes its size. The sample arithmetic can only be shown by the bench's scenarios. These are all sixteen phases on random windows, saturating and impulse windows that drive the filters past both clip limits, input gaps, phases that change in mid-block, and stray starts and samples.

// File: rtl/qpel_pkg.sv
package qpel_pkg;

    localparam int TAP_N = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } qpel_state_e;

    // add half of 2^sh, arithmetic shift, then saturate to 0..maxv
    function automatic int round_clip(input int v, input int sh, input int maxv);
        int t;
        t = (v + (1 << (sh - 1))) >>> sh;
        if (t < 0)
            return 0;
        if (t > maxv)
            return maxv;
        return t;
    endfunction

    function automatic int avg_up(input int a, input int b);
        return (a + b + 1) >>> 1;
    endfunction

endpackage

// File: rtl/qpel_fir6.sv
module qpel_fir6 #(
    parameter int IW = 9,
    parameter int OW = 15
) (
    input  logic [qpel_pkg::TAP_N-1:0][IW-1:0] taps_i,
    output logic signed [OW-1:0]               sum_o
);
    import qpel_pkg::*;

    logic signed [OW-1:0] ext [TAP_N];

    generate
        for (genvar k = 0; k < TAP_N; k++) begin : g_ext
            assign ext[k] = OW'($signed(taps_i[k]));
        end
    endgenerate

    // symmetric taps 1,-5,20,20,-5,1
    assign sum_o = OW'((ext[0] + ext[5]) - 5 * (ext[1] + ext[4]) + 20 * (ext[2] + ext[3]));

endmodule

// File: rtl/qpel_win_buf.sv
module qpel_win_buf #(
    parameter int SW  = 8,
    parameter int WIN = 13,
    parameter int BLK = 8,
    localparam int CELLS = WIN * WIN,
    localparam int CW    = $clog2(CELLS + 1),
    localparam int AW    = $clog2(CELLS),
    localparam int RW    = (BLK > 1) ? $clog2(BLK) : 1,
    localparam int PN    = qpel_pkg::TAP_N * qpel_pkg::TAP_N
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [SW-1:0]          wr_data,
    input  logic [RW-1:0]          rd_row,
    input  logic [RW-1:0]          rd_col,
    output logic [PN-1:0][SW-1:0]  patch,
    output logic                   full
);
    import qpel_pkg::*;

    typedef struct packed {
        logic [CELLS-1:0][SW-1:0] mem;
        logic [CW-1:0]            cnt;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d = wb_q;
        if (clr) begin
            wb_d.cnt = '0;
        end else if (wr_en && (wb_q.cnt != CW'(CELLS))) begin
            wb_d.mem[AW'(wb_q.cnt)] = wr_data;
            wb_d.cnt = wb_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wb_q <= '0;
        else
            wb_q <= wb_d;
    end

    assign full = (wb_q.cnt == CW'(CELLS));

    // 6x6 neighbourhood whose top-left corner is (rd_row, rd_col)
    always_comb begin
        for (int i = 0; i < TAP_N; i++) begin
            for (int j = 0; j < TAP_N; j++) begin
                patch[i*TAP_N + j] =
                    wb_q.mem[AW'((int'(rd_row) + i) * WIN + int'(rd_col) + j)];
            end
        end
    end

    // R2
    win_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_q.cnt <= CW'(CELLS));

    // R2
    win_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

endmodule

// File: rtl/qpel_interp_top.sv
module qpel_interp_top #(
    parameter int SW  = 8,
    parameter int BLK = 8,
    localparam int WIN  = BLK + qpel_pkg::TAP_N - 1,
    localparam int RW   = (BLK > 1) ? $clog2(BLK) : 1,
    localparam int PN   = qpel_pkg::TAP_N * qpel_pkg::TAP_N,
    localparam int VW   = SW + 1 + 6,
    localparam int JW   = VW + 6,
    localparam int MAXV = (1 << SW) - 1,
    localparam int OCW  = $clog2(BLK * BLK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start,
    input  logic [1:0]    frac_x,
    input  logic [1:0]    frac_y,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    output logic          blk_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_sample,
    output logic          out_last
);
    import qpel_pkg::*;

    typedef struct packed {
        qpel_state_e   st;
        logic [1:0]    fx;
        logic [1:0]    fy;
        logic [RW-1:0] row;
        logic [RW-1:0] col;
        logic          vld;
        logic          last;
        logic [SW-1:0] smp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PN-1:0][SW-1:0] patch;
    logic                  buf_full;
    logic                  buf_clr;
    logic                  buf_wr;

    assign buf_clr = (ctl_q.st == ST_IDLE) && blk_start;
    assign buf_wr  = (ctl_q.st == ST_LOAD) && in_valid;

    qpel_win_buf #(.SW(SW), .WIN(WIN), .BLK(BLK)) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_data (in_sample),
        .rd_row  (ctl_q.row),
        .rd_col  (ctl_q.col),
        .patch   (patch),
        .full    (buf_full)
    );

    // six column filters feed both the vertical halves and the centre
    logic [TAP_N-1:0][TAP_N-1:0][SW:0] vin;
    logic [TAP_N-1:0][VW-1:0]          vsum;
    logic [TAP_N-1:0][SW:0]            hin_b;
    logic [TAP_N-1:0][SW:0]            hin_s;
    logic signed [VW-1:0]              hsum_b;
    logic signed [VW-1:0]              hsum_s;
    logic signed [JW-1:0]              jsum;

    generate
        for (genvar k = 0; k < TAP_N; k++) begin : g_col
            for (genvar i = 0; i < TAP_N; i++) begin : g_row
                assign vin[k][i] = {1'b0, patch[i*TAP_N + k]};
            end
            qpel_fir6 #(.IW(SW + 1), .OW(VW)) vfir_i (
                .taps_i (vin[k]),
                .sum_o  (vsum[k])
            );
            assign hin_b[k] = {1'b0, patch[2*TAP_N + k]};
            assign hin_s[k] = {1'b0, patch[3*TAP_N + k]};
        end
    endgenerate

    qpel_fir6 #(.IW(SW + 1), .OW(VW)) hfir_b_i (.taps_i(hin_b), .sum_o(hsum_b));
    qpel_fir6 #(.IW(SW + 1), .OW(VW)) hfir_s_i (.taps_i(hin_s), .sum_o(hsum_s));
    qpel_fir6 #(.IW(VW),     .OW(JW)) jfir_i   (.taps_i(vsum),  .sum_o(jsum));

    logic [SW-1:0] p_g, p_hr, p_dn, p_b, p_s, p_h, p_m, p_j, interp;

    assign p_g  = patch[2*TAP_N + 2];
    assign p_hr = patch[2*TAP_N + 3];
    assign p_dn = patch[3*TAP_N + 2];
    assign p_b  = SW'(round_clip(int'(hsum_b), 5, MAXV));
    assign p_s  = SW'(round_clip(int'(hsum_s), 5, MAXV));
    assign p_h  = SW'(round_clip(int'($signed(vsum[2])), 5, MAXV));
    assign p_m  = SW'(round_clip(int'($signed(vsum[3])), 5, MAXV));
    assign p_j  = SW'(round_clip(int'(jsum), 10, MAXV));

    always_comb begin
        unique case ({ctl_q.fy, ctl_q.fx})
            4'b00_00: interp = p_g;
            4'b00_01: interp = SW'(avg_up(int'(p_g),  int'(p_b)));
            4'b00_10: interp = p_b;
            4'b00_11: interp = SW'(avg_up(int'(p_hr), int'(p_b)));
            4'b01_00: interp = SW'(avg_up(int'(p_g),  int'(p_h)));
            4'b01_01: interp = SW'(avg_up(int'(p_b),  int'(p_h)));
            4'b01_10: interp = SW'(avg_up(int'(p_b),  int'(p_j)));
            4'b01_11: interp = SW'(avg_up(int'(p_b),  int'(p_m)));
            4'b10_00: interp = p_h;
            4'b10_01: interp = SW'(avg_up(int'(p_h),  int'(p_j)));
            4'b10_10: interp = p_j;
            4'b10_11: interp = SW'(avg_up(int'(p_j),  int'(p_m)));
            4'b11_00: interp = SW'(avg_up(int'(p_dn), int'(p_h)));
            4'b11_01: interp = SW'(avg_up(int'(p_h),  int'(p_s)));
            4'b11_10: interp = SW'(avg_up(int'(p_j),  int'(p_s)));
            default:  interp = SW'(avg_up(int'(p_m),  int'(p_s)));
        endcase
    end

    logic at_end;
    assign at_end = (ctl_q.row == RW'(BLK - 1)) && (ctl_q.col == RW'(BLK - 1));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.vld  = 1'b0;
        ctl_d.last = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (blk_start) begin
                    ctl_d.st  = ST_LOAD;
                    ctl_d.fx  = frac_x;
                    ctl_d.fy  = frac_y;
                    ctl_d.row = '0;
                    ctl_d.col = '0;
                end
            end
            ST_LOAD: begin
                if (buf_full)
                    ctl_d.st = ST_EMIT;
            end
            ST_EMIT: begin
                ctl_d.vld  = 1'b1;
                ctl_d.smp  = interp;
                ctl_d.last = at_end;
                if (ctl_q.col == RW'(BLK - 1)) begin
                    ctl_d.col = '0;
                    ctl_d.row = ctl_q.row + 1'b1;
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
                if (at_end) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.row = '0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '{st: ST_IDLE, default: '0};
        else
            ctl_q <= ctl_d;
    end

    assign blk_ready  = (ctl_q.st == ST_IDLE);
    assign out_valid  = ctl_q.vld;
    assign out_sample = ctl_q.smp;
    assign out_last   = ctl_q.last;

    // checker-side count of samples emitted in the current block
    logic [OCW-1:0] ovc_q;
    always_ff @(posedge clk) begin
        if (!rst_n || out_last)
            ovc_q <= '0;
        else if (out_valid)
            ovc_q <= ovc_q + 1'b1;
    end

    // R3
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R3
    last_after_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (ovc_q == OCW'(BLK * BLK - 1)));

    // R3
    no_extra_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (ovc_q < OCW'(BLK * BLK - 1)));

    // R2
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ready && blk_start) |=> !blk_ready);

    // R10
    ready_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> blk_ready);

    // R10
    ready_rise_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_ready) |-> out_last);

endmodule

// File: tb/qpel_interp_top_tb.sv
module qpel_interp_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BLK = 8;
    localparam int WIN = BLK + 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start = 1'b0;
    logic [1:0] frac_x = '0;
    logic [1:0] frac_y = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic       blk_ready;
    logic       out_valid;
    logic [7:0] out_sample;
    logic       out_last;

    qpel_interp_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_start  (blk_start),
        .frac_x     (frac_x),
        .frac_y     (frac_y),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .blk_ready  (blk_ready),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_last   (out_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int w [WIN][WIN];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clip8(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int tap6(input int a, input int b, input int c,
                                input int d, input int e, input int f);
        return a - 5 * b + 20 * c + 20 * d - 5 * e + f;
    endfunction

    function automatic int half_row(input int y, input int x0);
        return clip8((tap6(w[y][x0], w[y][x0+1], w[y][x0+2],
                           w[y][x0+3], w[y][x0+4], w[y][x0+5]) + 16) >>> 5);
    endfunction

    function automatic int col_raw(input int x, input int y0);
        return tap6(w[y0][x], w[y0+1][x], w[y0+2][x], w[y0+3][x], w[y0+4][x], w[y0+5][x]);
    endfunction

    function automatic int half_col(input int x, input int y0);
        return clip8((col_raw(x, y0) + 16) >>> 5);
    endfunction

    function automatic int mean2(input int a, input int b);
        return (a + b + 1) >>> 1;
    endfunction

    function automatic int expect_at(input int r, input int c, input int fx, input int fy);
        int g, hr, dn, b, s, h, m, j;
        g  = w[r+2][c+2];
        hr = w[r+2][c+3];
        dn = w[r+3][c+2];
        b  = half_row(r + 2, c);
        s  = half_row(r + 3, c);
        h  = half_col(c + 2, r);
        m  = half_col(c + 3, r);
        j  = clip8((tap6(col_raw(c, r), col_raw(c+1, r), col_raw(c+2, r),
                         col_raw(c+3, r), col_raw(c+4, r), col_raw(c+5, r)) + 512) >>> 10);
        case ({fy[1:0], fx[1:0]})
            4'b0000: return g;
            4'b0001: return mean2(g, b);
            4'b0010: return b;
            4'b0011: return mean2(hr, b);
            4'b0100: return mean2(g, h);
            4'b0101: return mean2(b, h);
            4'b0110: return mean2(b, j);
            4'b0111: return mean2(b, m);
            4'b1000: return h;
            4'b1001: return mean2(h, j);
            4'b1010: return j;
            4'b1011: return mean2(j, m);
            4'b1100: return mean2(dn, h);
            4'b1101: return mean2(h, s);
            4'b1110: return mean2(j, s);
            default: return mean2(m, s);
        endcase
    endfunction

    function automatic string req_of(input int fx, input int fy);
        if (fx == 0 && fy == 0) return "R4";
        if (fx == 2 && fy == 2) return "R6";
        if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R5";
        return "R7";
    endfunction

    // 0 random, 1 all max, 2 sparse peaks, 3 column impulses (drive negative sums)
    task automatic fill_window(input int mode);
        for (int y = 0; y < WIN; y++) begin
            for (int x = 0; x < WIN; x++) begin
                case (mode)
                    1:       w[y][x] = 255;
                    2:       w[y][x] = (((y + x) % 3) == 0) ? 255 : 0;
                    3:       w[y][x] = (((x % 6) == 1) || ((y % 6) == 4)) ? 255 : 0;
                    default: w[y][x] = int'($urandom_range(0, 255));
                endcase
            end
        end
    endtask

    task automatic run_block(input int fx, input int fy, input int mode,
                             input bit gaps, input bit tamper);
        int n;
        int k;
        string rq;
        fill_window(mode);
        rq = req_of(fx, fy);
        @(negedge clk);
        check(blk_ready == 1'b1, "R10", int'(blk_ready), 1);
        blk_start = 1'b1;
        frac_x = 2'(fx);
        frac_y = 2'(fy);
        @(negedge clk);
        blk_start = 1'b0;
        if (tamper) begin
            // R8: phases moved after the start must not matter
            frac_x = ~2'(fx);
            frac_y = 2'(fy + 1);
        end
        check(blk_ready == 1'b0, "R2", int'(blk_ready), 0);
        for (int idx = 0; idx < WIN * WIN; idx++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                in_valid  = 1'b0;
                in_sample = 8'($urandom_range(0, 255));
                @(negedge clk);
            end
            in_valid  = 1'b1;
            in_sample = 8'(w[idx / WIN][idx % WIN]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        n = 0;
        k = 0;
        while (n < BLK * BLK && k < 400) begin
            if (out_valid) begin
                check(int'(out_sample) == expect_at(n / BLK, n % BLK, fx, fy),
                      rq, int'(out_sample), expect_at(n / BLK, n % BLK, fx, fy));
                check(out_last == (n == BLK * BLK - 1), "R3", int'(out_last),
                      int'(n == BLK * BLK - 1));
                if (out_last)
                    check(blk_ready == 1'b1, "R10", int'(blk_ready), 1);
                n++;
            end
            // R9: stray start and samples while emitting
            if (tamper && n == 5) begin
                blk_start = 1'b1;
                frac_x    = 2'd3;
                in_valid  = 1'b1;
                in_sample = 8'hA5;
            end else begin
                blk_start = 1'b0;
                in_valid  = 1'b0;
            end
            k++;
            if (n < BLK * BLK)
                @(negedge clk);
        end
        blk_start = 1'b0;
        in_valid  = 1'b0;
        check(n == BLK * BLK, "R3", n, BLK * BLK);
        @(negedge clk);
        check(out_valid == 1'b0, "R3", int'(out_valid), 0);
        check(blk_ready == 1'b1, "R9", int'(blk_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check(blk_ready == 1'b1, "R1", int'(blk_ready), 1);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_last == 1'b0, "R1", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(blk_ready == 1'b1, "R1", int'(blk_ready), 1);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R9: samples offered while idle are dropped
        for (int i = 0; i < 6; i++) begin
            in_valid  = 1'b1;
            in_sample = 8'($urandom_range(0, 255));
            @(negedge clk);
            check(out_valid == 1'b0, "R9", int'(out_valid), 0);
            check(blk_ready == 1'b1, "R9", int'(blk_ready), 1);
        end
        in_valid = 1'b0;

        // every phase on random windows (R4 R5 R6 R7), some with gaps (R2) or tampering (R8 R9)
        for (int ph = 0; ph < 16; ph++)
            run_block(ph % 4, ph / 4, 0, (ph % 2) == 1, (ph % 5) == 0);

        // clip corners
        run_block(2, 2, 1, 1'b0, 1'b0);
        run_block(2, 2, 3, 1'b0, 1'b0);
        run_block(0, 0, 3, 1'b1, 1'b1);
        run_block(1, 0, 3, 1'b0, 1'b0);
        run_block(3, 3, 2, 1'b0, 1'b1);
        run_block(2, 1, 3, 1'b1, 1'b0);
        run_block(0, 2, 1, 1'b0, 1'b0);
        run_block(2, 0, 2, 1'b0, 1'b0);
        run_block(1, 3, 3, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule